// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank-State Tracker

This block watches the command pins of a DDR2 memory device on every rising clock edge and keeps a model of the device's state. It turns the chip-select and strobe pins into one-cycle command pulses. It records, for every bank, whether a row is open and which row that is. It stores the op-codes written by mode-register loads. It also follows the device through its low-power states. A controller, a protocol monitor or a memory model can use it to see what the device will do with the next command.

Commands are acted on only while the device is powered up and the clock enable is high. Illegal bank accesses are refused and set a sticky error flag. Termination is granted only when the extended mode register enables it and the device is not in self refresh. Data timing, strobe capture, refresh counting and electrical behaviour are outside this block.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: With `cs_n` high at a clock edge, no strobe fires in the following cycle, and no bank, row or mode register changes because of that edge.
- R2: The command code {cs_n, ras_n, cas_n, we_n} decodes as 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh and 0000 mode load. Any other code with `cs_n` low is a no-op. An accepted command raises its strobe for exactly the one cycle after its edge, and at most one strobe is high at a time.
- R3: An accepted activate marks bank `ba` open from the cycle after its edge and stores `addr` as that bank's row in `open_rows[ba*ROW_W +: ROW_W]`.
- R4: A precharge with `addr[10]` low closes only bank `ba`. A precharge with `addr[10]` high closes every bank.
- R5: An accepted read or write presents `cmd_bank` = `ba`, `cmd_ap` = `addr[10]`, and `cmd_col` = `addr` with bit 10 cleared, in the cycle after its edge.
- R6: A read or write with `addr[10]` high leaves its bank open in the cycle after the command, and the bank is closed from the edge after that.
- R7: An activate to an open bank, or a read or write to an idle bank, is refused. No strobe fires, bank state and row are unchanged, and `proto_err` rises and stays high until reset.
- R8: A mode load with `ba` in 0..3 writes `addr` into `mode_regs[ba*ADDR_W +: ADDR_W]` and pulses `lmr_stb`. With `ba` of 4 or more it writes nothing and no strobe fires.
- R9: In the powered-up state (`pwr_state` 00), an edge with `cke` low enters a low-power state. It enters self refresh (11) if the command is refresh and no bank is open. It enters active power-down (10) if any bank is open, and precharge power-down (01) otherwise. The command at that edge is not executed.
- R10: From either power-down state, an edge with `cke` high returns to 00. Commands sampled while powered down, including the one at the exit edge, are ignored.
- R11: In self refresh, `pwr_state` reads 00 as soon as `cke` is high, without waiting for a clock edge.
- R12: `odt_en` is `odt_in` AND (bit 2 OR bit 6 of mode register 1), and is forced low while `pwr_state` is 11.
- R13: A synchronous active-high `rst` closes all banks, clears rows, mode registers, strobes and `proto_err`, and sets `pwr_state` to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address bus |
| odt_in | input | 1 | Termination request pin |
| act_stb | output | 1 | Activate accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| pre_stb | output | 1 | Precharge accepted |
| ref_stb | output | 1 | Refresh accepted |
| lmr_stb | output | 1 | Mode register written |
| cmd_bank | output | BANK_W | Bank of last accepted read or write |
| cmd_col | output | ADDR_W | Column of last accepted read or write |
| cmd_ap | output | 1 | Auto-precharge flag of last read or write |
| bank_open | output | NUM_BANKS | One bit per bank, high when a row is open |
| open_rows | output | NUM_BANKS*ROW_W | Stored row per bank |
| mode_regs | output | NUM_MR*ADDR_W | Contents of the mode registers |
| pwr_state | output | 2 | 00 up, 01 precharge power-down, 10 active power-down, 11 self refresh |
| odt_en | output | 1 | Termination granted |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its defaults: eight banks, a 14-bit address bus with full-width row storage kept on, four mode registers, auto-precharge on bit 10 and termination enables on bits 2 and 6. The wide address reaches row values near the top of the bus and shows that clearing bit 10 leaves the other column bits alone. With eight banks, a bank index above the last mode register is reachable, so the ignored-load case can be checked. Keeping row storage on lets the bench read back rows and confirm that a refused activate leaves the stored row unchanged.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_LMR,
      CMD_DESEL
   } cmd_e;

   typedef enum logic [1:0] {
      PWR_UP   = 2'd0,
      PWR_PPD  = 2'd1,
      PWR_APD  = 2'd2,
      PWR_SREF = 2'd3
   } pwr_e;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
   import ddr2_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      casez ({cs_n, ras_n, cas_n, we_n})
         4'b1???: cmd = CMD_DESEL;
         4'b0011: cmd = CMD_ACT;
         4'b0101: cmd = CMD_RD;
         4'b0100: cmd = CMD_WR;
         4'b0010: cmd = CMD_PRE;
         4'b0001: cmd = CMD_REF;
         4'b0000: cmd = CMD_LMR;
         default: cmd = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/ddr2_power_ctl.sv
module ddr2_power_ctl
   import ddr2_trk_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cke,
   input  cmd_e cmd,
   input  logic any_open,
   output pwr_e pwr_vis,
   output logic exec
);

   pwr_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PWR_UP: begin
            if (!cke) begin
               if (any_open)
                  state_d = PWR_APD;
               else if (cmd == CMD_REF)
                  state_d = PWR_SREF;
               else
                  state_d = PWR_PPD;
            end
         end
         PWR_PPD, PWR_APD, PWR_SREF: begin
            if (cke) state_d = PWR_UP;
         end
         default: state_d = PWR_UP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= PWR_UP;
      else     state_q <= state_d;
   end

   // self-refresh exit is seen on the pin level, ahead of the clock
   assign pwr_vis = (state_q == PWR_SREF && cke) ? PWR_UP : state_q;
   assign exec    = (state_q == PWR_UP) && cke;

endmodule

// File: rtl/ddr2_bank_table.sv
module ddr2_bank_table
   import ddr2_trk_pkg::*;
#(
   parameter int NUM_BANKS  = 8,
   parameter int BANK_W     = 3,
   parameter int ADDR_W     = 14,
   parameter int ROW_W      = 14,
   parameter int AP_BIT     = 10,
   parameter bit TRACK_ROWS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       exec,
   input  cmd_e                       cmd,
   input  logic [BANK_W-1:0]          ba,
   input  logic [ADDR_W-1:0]          addr,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] row_flat,
   output logic                       act_acc,
   output logic                       rw_acc,
   output logic                       err_q
);

   logic              act_req, rw_req, pre_req, hit_open;
   logic              ap_pend_q;
   logic [BANK_W-1:0] ap_bank_q;

   assign hit_open = bank_open[ba];
   assign act_req  = exec && (cmd == CMD_ACT);
   assign rw_req   = exec && (cmd == CMD_RD || cmd == CMD_WR);
   assign pre_req  = exec && (cmd == CMD_PRE);
   assign act_acc  = act_req && !hit_open;
   assign rw_acc   = rw_req && hit_open;

   always_ff @(posedge clk) begin
      if (rst) begin
         ap_pend_q <= 1'b0;
         ap_bank_q <= '0;
         err_q     <= 1'b0;
      end else begin
         ap_pend_q <= rw_acc && addr[AP_BIT];
         ap_bank_q <= ba;
         err_q     <= err_q | (act_req && hit_open) | (rw_req && !hit_open);
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel, closing, open_q;

      assign sel     = (ba == BANK_W'(b));
      assign closing = (pre_req && (addr[AP_BIT] || sel))
                    || (ap_pend_q && ap_bank_q == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (rst)                 open_q <= 1'b0;
         else if (act_acc && sel) open_q <= 1'b1;
         else if (closing)        open_q <= 1'b0;
      end
      assign bank_open[b] = open_q;

      if (TRACK_ROWS) begin : g_row
         logic [ROW_W-1:0] row_q;
         always_ff @(posedge clk) begin
            if (rst)                 row_q <= '0;
            else if (act_acc && sel) row_q <= addr[ROW_W-1:0];
         end
         assign row_flat[b*ROW_W +: ROW_W] = row_q;
      end else begin : g_norow
         assign row_flat[b*ROW_W +: ROW_W] = '0;
      end
   end

endmodule

// File: rtl/ddr2_mode_bank.sv
module ddr2_mode_bank #(
   parameter int NUM_MR     = 4,
   parameter int ADDR_W     = 14,
   parameter int BANK_W     = 3,
   parameter int TERM_IDX   = 1,
   parameter int RTT_LO_BIT = 2,
   parameter int RTT_HI_BIT = 6
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [BANK_W-1:0]        ba,
   input  logic [ADDR_W-1:0]        addr,
   output logic [NUM_MR*ADDR_W-1:0] mode_flat,
   output logic                     term_on
);

   localparam int TERM_BASE = TERM_IDX * ADDR_W;

   for (genvar k = 0; k < NUM_MR; k++) begin : g_mr
      logic [ADDR_W-1:0] reg_q;
      always_ff @(posedge clk) begin
         if (rst)                               reg_q <= '0;
         else if (wr_en && ba == BANK_W'(k))    reg_q <= addr;
      end
      assign mode_flat[k*ADDR_W +: ADDR_W] = reg_q;
   end

   assign term_on = mode_flat[TERM_BASE + RTT_LO_BIT] | mode_flat[TERM_BASE + RTT_HI_BIT];

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
   import ddr2_trk_pkg::*;
#(
   parameter int NUM_BANKS  = 8,
   parameter int ADDR_W     = 14,
   parameter int ROW_W      = 14,
   parameter int NUM_MR     = 4,
   parameter int AP_BIT     = 10,
   parameter int TERM_IDX   = 1,
   parameter int RTT_LO_BIT = 2,
   parameter int RTT_HI_BIT = 6,
   parameter bit TRACK_ROWS = 1'b1,
   localparam int BANK_W    = $clog2(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        cke,
   input  logic                        cs_n,
   input  logic                        ras_n,
   input  logic                        cas_n,
   input  logic                        we_n,
   input  logic [BANK_W-1:0]           ba,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        odt_in,
   output logic                        act_stb,
   output logic                        rd_stb,
   output logic                        wr_stb,
   output logic                        pre_stb,
   output logic                        ref_stb,
   output logic                        lmr_stb,
   output logic [BANK_W-1:0]           cmd_bank,
   output logic [ADDR_W-1:0]           cmd_col,
   output logic                        cmd_ap,
   output logic [NUM_BANKS-1:0]        bank_open,
   output logic [NUM_BANKS*ROW_W-1:0]  open_rows,
   output logic [NUM_MR*ADDR_W-1:0]    mode_regs,
   output logic [1:0]                  pwr_state,
   output logic                        odt_en,
   output logic                        proto_err
);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end
   if (ROW_W < 1 || ROW_W > ADDR_W) begin : g_bad_row
      $error("ROW_W must be between 1 and ADDR_W");
   end
   if (NUM_MR < 1 || NUM_MR > NUM_BANKS || TERM_IDX >= NUM_MR) begin : g_bad_mr
      $error("mode register count or termination index out of range");
   end
   if (RTT_LO_BIT >= ADDR_W || RTT_HI_BIT >= ADDR_W) begin : g_bad_rtt
      $error("termination bits must lie inside the address bus");
   end

   cmd_e              cmd;
   pwr_e              pwr_vis;
   logic              exec, act_acc, rw_acc, term_on, lmr_hit;
   logic [ADDR_W-1:0] col_v;

   ddr2_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   ddr2_power_ctl u_pwr (
      .clk      (clk),
      .rst      (rst),
      .cke      (cke),
      .cmd      (cmd),
      .any_open (|bank_open),
      .pwr_vis  (pwr_vis),
      .exec     (exec)
   );

   ddr2_bank_table #(
      .NUM_BANKS  (NUM_BANKS),
      .BANK_W     (BANK_W),
      .ADDR_W     (ADDR_W),
      .ROW_W      (ROW_W),
      .AP_BIT     (AP_BIT),
      .TRACK_ROWS (TRACK_ROWS)
   ) u_banks (
      .clk       (clk),
      .rst       (rst),
      .exec      (exec),
      .cmd       (cmd),
      .ba        (ba),
      .addr      (addr),
      .bank_open (bank_open),
      .row_flat  (open_rows),
      .act_acc   (act_acc),
      .rw_acc    (rw_acc),
      .err_q     (proto_err)
   );

   assign lmr_hit = exec && (cmd == CMD_LMR) && (int'(ba) < NUM_MR);

   ddr2_mode_bank #(
      .NUM_MR     (NUM_MR),
      .ADDR_W     (ADDR_W),
      .BANK_W     (BANK_W),
      .TERM_IDX   (TERM_IDX),
      .RTT_LO_BIT (RTT_LO_BIT),
      .RTT_HI_BIT (RTT_HI_BIT)
   ) u_mode (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (lmr_hit),
      .ba        (ba),
      .addr      (addr),
      .mode_flat (mode_regs),
      .term_on   (term_on)
   );

   always_comb begin
      col_v         = addr;
      col_v[AP_BIT] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_stb  <= 1'b0;
         rd_stb   <= 1'b0;
         wr_stb   <= 1'b0;
         pre_stb  <= 1'b0;
         ref_stb  <= 1'b0;
         lmr_stb  <= 1'b0;
         cmd_bank <= '0;
         cmd_col  <= '0;
         cmd_ap   <= 1'b0;
      end else begin
         act_stb <= act_acc;
         rd_stb  <= rw_acc && (cmd == CMD_RD);
         wr_stb  <= rw_acc && (cmd == CMD_WR);
         pre_stb <= exec && (cmd == CMD_PRE);
         ref_stb <= exec && (cmd == CMD_REF);
         lmr_stb <= lmr_hit;
         if (rw_acc) begin
            cmd_bank <= ba;
            cmd_col  <= col_v;
            cmd_ap   <= addr[AP_BIT];
         end
      end
   end

   assign pwr_state = pwr_vis;
   assign odt_en    = odt_in && term_on && (pwr_vis != PWR_SREF);

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 14,
   parameter int NUM_MR    = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     cke,
   input logic                     cs_n,
   input logic                     act_stb,
   input logic                     rd_stb,
   input logic                     wr_stb,
   input logic                     pre_stb,
   input logic                     ref_stb,
   input logic                     lmr_stb,
   input logic                     cmd_ap,
   input logic [BANK_W-1:0]        cmd_bank,
   input logic [NUM_BANKS-1:0]     bank_open,
   input logic [NUM_MR*ADDR_W-1:0] mode_regs,
   input logic [1:0]               pwr_state,
   input logic                     proto_err
);

   // R1
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> !(act_stb || rd_stb || wr_stb || pre_stb || ref_stb || lmr_stb));

   // R1
   deselect_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> $stable(mode_regs));

   // R2
   single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, lmr_stb}));

   // R6
   auto_close_chk: assert property (@(posedge clk) disable iff (rst)
      ((rd_stb || wr_stb) && cmd_ap) |=> !bank_open[$past(cmd_bank)]);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err);

   // R9
   access_powered_chk: assert property (@(posedge clk) disable iff (rst)
      (act_stb || rd_stb || wr_stb) |-> (pwr_state == 2'd0));

   // R11
   sref_exit_chk: assert property (@(posedge clk) disable iff (rst)
      cke |-> (pwr_state != 2'd3));

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .NUM_MR    (NUM_MR)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cke       (cke),
   .cs_n      (cs_n),
   .act_stb   (act_stb),
   .rd_stb    (rd_stb),
   .wr_stb    (wr_stb),
   .pre_stb   (pre_stb),
   .ref_stb   (ref_stb),
   .lmr_stb   (lmr_stb),
   .cmd_ap    (cmd_ap),
   .cmd_bank  (cmd_bank),
   .bank_open (bank_open),
   .mode_regs (mode_regs),
   .pwr_state (pwr_state),
   .proto_err (proto_err)
);

// File: tb/ddr2_cmd_tracker_test.sv
`timescale 1ns/1ps
module ddr2_cmd_tracker_test;

   localparam int NB = 8;
   localparam int AW = 14;
   localparam int RW = 14;
   localparam int NM = 4;

   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                          C_LMR = 4'b0000, C_DES = 4'b1011;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            cke = 1'b1;
   logic            cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]      ba = '0;
   logic [AW-1:0]   addr = '0;
   logic            odt_in = 1'b0;
   logic            act_stb, rd_stb, wr_stb, pre_stb, ref_stb, lmr_stb;
   logic [2:0]      cmd_bank;
   logic [AW-1:0]   cmd_col;
   logic            cmd_ap;
   logic [NB-1:0]   bank_open;
   logic [NB*RW-1:0] open_rows;
   logic [NM*AW-1:0] mode_regs;
   logic [1:0]      pwr_state;
   logic            odt_en, proto_err;
   logic [5:0]      stb;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   ddr2_cmd_tracker uut (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .odt_in(odt_in),
      .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
      .ref_stb(ref_stb), .lmr_stb(lmr_stb), .cmd_bank(cmd_bank),
      .cmd_col(cmd_col), .cmd_ap(cmd_ap), .bank_open(bank_open),
      .open_rows(open_rows), .mode_regs(mode_regs), .pwr_state(pwr_state),
      .odt_en(odt_en), .proto_err(proto_err)
   );

   assign stb = {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, lmr_stb};

   typedef struct packed {
      logic          cke;
      logic [3:0]    cmd;
      logic [2:0]    ba;
      logic [13:0]   addr;
      logic [7:0]    open;
      logic [5:0]    stb;
      logic [1:0]    pwr;
      logic          err;
   } vec_t;

   localparam vec_t TBL [14] = '{
      '{1'b1, C_ACT, 3'd0, 14'h0123, 8'h01, 6'b100000, 2'd0, 1'b0},
      '{1'b1, C_ACT, 3'd3, 14'h0456, 8'h09, 6'b100000, 2'd0, 1'b0},
      '{1'b1, C_RD,  3'd0, 14'h0010, 8'h09, 6'b010000, 2'd0, 1'b0},
      '{1'b1, C_WR,  3'd3, 14'h0420, 8'h09, 6'b001000, 2'd0, 1'b0},
      '{1'b1, C_NOP, 3'd0, 14'h0000, 8'h01, 6'b000000, 2'd0, 1'b0},
      '{1'b1, C_DES, 3'd5, 14'h0777, 8'h01, 6'b000000, 2'd0, 1'b0},
      '{1'b1, C_PRE, 3'd0, 14'h0000, 8'h00, 6'b000100, 2'd0, 1'b0},
      '{1'b1, C_ACT, 3'd7, 14'h1FFF, 8'h80, 6'b100000, 2'd0, 1'b0},
      '{1'b1, C_ACT, 3'd2, 14'h0002, 8'h84, 6'b100000, 2'd0, 1'b0},
      '{1'b1, C_PRE, 3'd0, 14'h0400, 8'h00, 6'b000100, 2'd0, 1'b0},
      '{1'b1, C_REF, 3'd0, 14'h0000, 8'h00, 6'b000010, 2'd0, 1'b0},
      '{1'b1, C_LMR, 3'd1, 14'h0044, 8'h00, 6'b000001, 2'd0, 1'b0},
      '{1'b1, C_RD,  3'd4, 14'h0000, 8'h00, 6'b000000, 2'd0, 1'b1},
      '{1'b1, C_NOP, 3'd0, 14'h0000, 8'h00, 6'b000000, 2'd0, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic k, input logic [3:0] c, input logic [2:0] b,
                        input logic [AW-1:0] a);
      cke = k;
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b;
      addr = a;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cke = 1'b1;
      {cs_n, ras_n, cas_n, we_n} = C_NOP;
      repeat (3) @(posedge clk);
      #1;
      check("R13 reset banks", 32'(bank_open), 32'h0);
      check("R13 reset error", 32'(proto_err), 32'h0);
      check("R13 reset power", 32'(pwr_state), 32'h0);
      check("R13 reset strobes", 32'(stb), 32'h0);
      check("R13 reset mode1", 32'(mode_regs[1*AW +: AW]), 32'h0);
      check("R13 reset row7", 32'(open_rows[7*RW +: RW]), 32'h0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      do_reset();

      // table walk: R1 R2 R3 R4 R6 R7 R8
      for (int i = 0; i < 14; i++) begin
         apply(TBL[i].cke, TBL[i].cmd, TBL[i].ba, TBL[i].addr);
         check($sformatf("R2 vec%0d strobes", i), 32'(stb), 32'(TBL[i].stb));
         check($sformatf("R4 vec%0d banks", i), 32'(bank_open), 32'(TBL[i].open));
         check($sformatf("R9 vec%0d power", i), 32'(pwr_state), 32'(TBL[i].pwr));
         check($sformatf("R7 vec%0d error", i), 32'(proto_err), 32'(TBL[i].err));
      end
      check("R3 row bank7", 32'(open_rows[7*RW +: RW]), 32'h1FFF);
      check("R1 deselect left bank5 row", 32'(open_rows[5*RW +: RW]), 32'h0);

      // mode registers, R8
      check("R8 mode1 written", 32'(mode_regs[1*AW +: AW]), 32'h0044);
      apply(1'b1, C_LMR, 3'd5, 14'h3FFF);
      check("R8 ba5 no strobe", 32'(lmr_stb), 32'h0);
      check("R8 ba5 no write", 32'(mode_regs), {8'h0, 14'h0, 14'h0, 14'h0044, 14'h0} >> 0);
      apply(1'b1, C_LMR, 3'd3, 14'h0123);
      check("R8 mode3 written", 32'(mode_regs[3*AW +: AW]), 32'h0123);

      // termination, R12
      odt_in = 1'b1;
      #1;
      check("R12 odt granted", 32'(odt_en), 32'h1);
      apply(1'b1, C_LMR, 3'd1, 14'h0000);
      check("R12 odt disabled by mode", 32'(odt_en), 32'h0);

      do_reset();

      // R3 R7 row storage and refused activate
      apply(1'b1, C_ACT, 3'd6, 14'h0ABC);
      check("R3 bank6 open", 32'(bank_open), 32'h40);
      check("R3 bank6 row", 32'(open_rows[6*RW +: RW]), 32'h0ABC);
      apply(1'b1, C_ACT, 3'd6, 14'h0111);
      check("R7 refused act strobe", 32'(act_stb), 32'h0);
      check("R7 refused act row", 32'(open_rows[6*RW +: RW]), 32'h0ABC);
      check("R7 refused act error", 32'(proto_err), 32'h1);

      // R5 R6 read with auto-precharge
      apply(1'b1, C_RD, 3'd6, 14'h0455);
      check("R5 read strobe", 32'(rd_stb), 32'h1);
      check("R5 column", 32'(cmd_col), 32'h0055);
      check("R5 ap flag", 32'(cmd_ap), 32'h1);
      check("R5 bank", 32'(cmd_bank), 32'h6);
      check("R6 still open", 32'(bank_open), 32'h40);
      apply(1'b1, C_NOP, 3'd0, 14'h0000);
      check("R6 closed next edge", 32'(bank_open), 32'h0);

      do_reset();

      // power states R9 R10 R11
      apply(1'b0, C_NOP, 3'd0, 14'h0000);
      check("R9 precharge power-down", 32'(pwr_state), 32'h1);
      apply(1'b0, C_ACT, 3'd2, 14'h0000);
      check("R10 act ignored in power-down", 32'(bank_open), 32'h0);
      apply(1'b1, C_ACT, 3'd2, 14'h0000);
      check("R10 exit to up", 32'(pwr_state), 32'h0);
      check("R10 exit edge act ignored", 32'(bank_open), 32'h0);
      apply(1'b1, C_ACT, 3'd2, 14'h0000);
      check("R10 act after exit", 32'(bank_open), 32'h04);
      apply(1'b0, C_NOP, 3'd0, 14'h0000);
      check("R9 active power-down", 32'(pwr_state), 32'h2);
      apply(1'b1, C_NOP, 3'd0, 14'h0000);
      check("R10 exit active power-down", 32'(pwr_state), 32'h0);
      apply(1'b1, C_PRE, 3'd0, 14'h0400);
      apply(1'b1, C_LMR, 3'd1, 14'h0004);
      check("R12 odt granted bit2", 32'(odt_en), 32'h1);
      apply(1'b0, C_REF, 3'd0, 14'h0000);
      check("R9 self refresh", 32'(pwr_state), 32'h3);
      check("R9 entry refresh not executed", 32'(ref_stb), 32'h0);
      check("R12 odt off in self refresh", 32'(odt_en), 32'h0);
      cke = 1'b1;
      #1;
      check("R11 exit before clock", 32'(pwr_state), 32'h0);
      apply(1'b1, C_NOP, 3'd0, 14'h0000);
      check("R11 up after edge", 32'(pwr_state), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule